// File: doc/BRIEF.md
# Burst Scheduler with Fast and Low-Power Pacing

This block decides when the next capacitive measurement burst begins. A burst is treated as a handshake: the scheduler raises a one-cycle start strobe, and the burst engine answers with a one-cycle done strobe when it has finished. After each done strobe the scheduler waits out a gap, counted in millisecond ticks, and then starts the next burst.

The gap length depends on how urgent sensing is. While the switched output is on, short gaps keep the response quick. While the output is off, long sleep gaps save power. A possible but still unconfirmed touch promotes the block to short gaps, so that the detect integrator gets its confirmations quickly. The block falls back to long gaps once the touch is rejected, and stays on short gaps if the touch is confirmed.

An override inhibit input suspends bursts completely. When the inhibit is released, or when reset ends, the next burst starts at once, with no gap. The mode indicator is refreshed only when a burst completes.

Top module: `burst_sched`

## Requirements
- R1: While reset is asserted, burstStart is 0 and fastMode is 0 (low-power pacing).
- R2: When outOn is 1 in the cycle burstDone is sampled, the next burstStart follows after FAST_GAP ticks and fastMode is 1.
- R3: When outOn, touchPending and touchConfirmed are all 0 at burstDone, the next burstStart follows after SLOW_GAP ticks and fastMode is 0.
- R4: With outOn at 0, touchPending at 1 at burstDone selects the FAST_GAP gap and fastMode 1.
- R5: When touchPending has dropped without confirmation, the next gap is SLOW_GAP again. When touchConfirmed is 1 at burstDone, the gap is FAST_GAP.
- R6: After reset release, or after inhibit falls, burstStart is 1 in the cycle that follows the first clock edge that samples inhibit at 0, with no gap.
- R7: No burstStart occurs while inhibit is 1. A gap interrupted by inhibit is abandoned, not resumed.
- R8: fastMode changes only at a clock edge that samples burstDone at 1. It holds through a gap even if outOn or the touch flags change.
- R9: burstStart is exactly one cycle wide. A gap counts msTick pulses sampled at edges after the burstDone edge, and the start follows the edge of the last counted tick. Ticks seen while a burst is in progress are not counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| outOn | input | 1 | Switched output is in its on state |
| touchPending | input | 1 | Possible touch not yet confirmed or rejected |
| touchConfirmed | input | 1 | Touch confirmed by the detect integrator |
| inhibit | input | 1 | Override inhibit; suspends bursts |
| burstDone | input | 1 | One-cycle strobe: current burst finished |
| msTick | input | 1 | One-cycle millisecond tick |
| burstStart | output | 1 | One-cycle strobe: begin a burst |
| fastMode | output | 1 | 1 for short-gap pacing, 0 for low-power pacing |

## Verification
The embedded properties check on every cycle that a start never follows a cycle with inhibit high and is always a single cycle wide. They also check that a pending release out of the hold state leads straight to a start, that the mode flag moves only when the control loads it, and that the gap counter never steps below zero. The exact gap length for each combination of output state and touch flags can only be shown by the bench's scenarios, which measure ticks between done and start. The same holds for fallback after a rejected touch, abandonment of an inhibited gap, and mode retention while inputs change during a gap.

// File: rtl/burst_sched_pkg.sv
package burst_sched_pkg;

  typedef enum logic [1:0] {
    ST_HOLD   = 2'd0,
    ST_LAUNCH = 2'd1,
    ST_BUSY   = 2'd2,
    ST_GAP    = 2'd3
  } schedState_t;

  typedef struct packed {
    logic gapLoad;   // load the gap counter at burst completion
    logic gapFast;   // pick the short gap for the load
    logic gapStep;   // count one tick of the gap
    logic modeLoad;  // refresh the mode flag
    logic modeFast;  // value for the mode flag
  } schedStrobe_t;

endpackage

// File: rtl/burst_sched_dp.sv
module burst_sched_dp
  import burst_sched_pkg::*;
#(
  parameter int unsigned FAST_GAP = 3,
  parameter int unsigned SLOW_GAP = 85
) (
  input  logic         clk,
  input  logic         rstN,
  input  schedStrobe_t ctl,
  output logic         gapLast,
  output logic         fastMode
);

  localparam int unsigned GAP_MAX = (FAST_GAP > SLOW_GAP) ? FAST_GAP : SLOW_GAP;
  localparam int unsigned CW      = $clog2(GAP_MAX + 1);
  localparam logic [CW-1:0] FAST_LD = CW'(FAST_GAP);
  localparam logic [CW-1:0] SLOW_LD = CW'(SLOW_GAP);

  logic [CW-1:0] gapCnt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      gapCnt <= '0;
    end else if (ctl.gapLoad) begin
      gapCnt <= ctl.gapFast ? FAST_LD : SLOW_LD;
    end else if (ctl.gapStep && (gapCnt != '0)) begin
      gapCnt <= gapCnt - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      fastMode <= 1'b0;
    end else if (ctl.modeLoad) begin
      fastMode <= ctl.modeFast;
    end
  end

  assign gapLast = (gapCnt == CW'(1));

  // R9
  gap_underflow_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctl.gapStep |-> (gapCnt != '0));

  // R9
  gap_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctl.gapLoad |=> (gapCnt != '0));

  // R8
  mode_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.modeLoad |=> $stable(fastMode));

endmodule

// File: rtl/burst_sched_ctl.sv
module burst_sched_ctl
  import burst_sched_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         outOn,
  input  logic         touchPending,
  input  logic         touchConfirmed,
  input  logic         inhibit,
  input  logic         burstDone,
  input  logic         msTick,
  input  logic         gapLast,
  output schedStrobe_t ctl,
  output logic         burstStart
);

  schedState_t state, stateNxt;
  logic        wantFast;

  assign wantFast = outOn | touchPending | touchConfirmed;

  always_comb begin
    stateNxt = state;
    unique case (state)
      ST_HOLD:   if (!inhibit) stateNxt = ST_LAUNCH;
      ST_LAUNCH: stateNxt = ST_BUSY;
      ST_BUSY:   if (burstDone) stateNxt = inhibit ? ST_HOLD : ST_GAP;
      ST_GAP: begin
        if (inhibit)                 stateNxt = ST_HOLD;
        else if (msTick && gapLast)  stateNxt = ST_LAUNCH;
      end
      default:   stateNxt = ST_HOLD;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_HOLD;
    else       state <= stateNxt;
  end

  always_comb begin
    ctl          = '0;
    ctl.gapLoad  = (state == ST_BUSY) && burstDone;
    ctl.gapFast  = wantFast;
    ctl.gapStep  = (state == ST_GAP) && msTick && !inhibit;
    ctl.modeLoad = (state == ST_BUSY) && burstDone;
    ctl.modeFast = wantFast;
  end

  assign burstStart = (state == ST_LAUNCH);

  // R7
  start_inhibit_chk: assert property (@(posedge clk) disable iff (!rstN)
    burstStart |-> !$past(inhibit));

  // R9
  start_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    burstStart |=> !burstStart);

  // R6
  hold_release_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_HOLD && !inhibit) |=> burstStart);

endmodule

// File: rtl/burst_sched.sv
module burst_sched
  import burst_sched_pkg::*;
#(
  parameter int unsigned FAST_GAP = 3,
  parameter int unsigned SLOW_GAP = 85
) (
  input  logic clk,
  input  logic rstN,
  input  logic outOn,
  input  logic touchPending,
  input  logic touchConfirmed,
  input  logic inhibit,
  input  logic burstDone,
  input  logic msTick,
  output logic burstStart,
  output logic fastMode
);

  schedStrobe_t ctl;
  logic         gapLast;

  burst_sched_ctl u_ctl (
    .clk            (clk),
    .rstN           (rstN),
    .outOn          (outOn),
    .touchPending   (touchPending),
    .touchConfirmed (touchConfirmed),
    .inhibit        (inhibit),
    .burstDone      (burstDone),
    .msTick         (msTick),
    .gapLast        (gapLast),
    .ctl            (ctl),
    .burstStart     (burstStart)
  );

  burst_sched_dp #(
    .FAST_GAP (FAST_GAP),
    .SLOW_GAP (SLOW_GAP)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .ctl      (ctl),
    .gapLast  (gapLast),
    .fastMode (fastMode)
  );

endmodule

// File: tb/burst_sched_tb.sv
`timescale 1ns/1ps
module burst_sched_tb;

  localparam int FAST_T = 3;
  localparam int SLOW_T = 20;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic outOn = 1'b0, touchPending = 1'b0, touchConfirmed = 1'b0;
  logic inhibit = 1'b0, burstDone = 1'b0, msTick = 1'b0;
  logic burstStart, fastMode;

  burst_sched #(.FAST_GAP(FAST_T), .SLOW_GAP(SLOW_T)) u_dut (
    .clk(clk), .rstN(rstN), .outOn(outOn), .touchPending(touchPending),
    .touchConfirmed(touchConfirmed), .inhibit(inhibit), .burstDone(burstDone),
    .msTick(msTick), .burstStart(burstStart), .fastMode(fastMode)
  );

  always #2.5 clk = ~clk;

  typedef struct {
    int    gap;
    bit    fast;
    string req;
  } expItem_t;

  expItem_t expQ[$];
  int checks = 0, fails = 0;
  int cyc = 0, tickCnt = 0, startSeen = 0;
  bit armed = 1'b0;

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  always @(posedge clk) cyc++;

  always @(negedge clk) msTick <= (cyc % 4 == 1);

  // monitor: measures ticks between done and start
  always @(posedge clk) begin
    if (!rstN || inhibit) armed = 1'b0;
    else if (burstDone) begin armed = 1'b1; tickCnt = 0; end
    else if (armed && msTick) tickCnt++;
  end

  always @(negedge clk) begin
    if (rstN && burstStart) begin
      startSeen++;
      if (armed) begin
        if (expQ.size() == 0) begin
          check(1'b0, "queue", 0, 1);
        end else begin
          expItem_t e;
          e = expQ.pop_front();
          check(tickCnt == e.gap, e.req, tickCnt, e.gap);
          check(fastMode == e.fast, e.req, int'(fastMode), int'(e.fast));
        end
        armed = 1'b0;
      end
    end
  end

  task automatic pulseDone(bit push, int gap, bit fast, string req);
    burstDone = 1'b1;
    if (push) expQ.push_back('{gap, fast, req});
    @(negedge clk);
    burstDone = 1'b0;
  endtask

  task automatic waitStart();
    while (!burstStart) @(negedge clk);
  endtask

  task automatic runBurst(int busy, bit o, bit tp, bit tc, int gap, bit fast, string req);
    waitStart();
    outOn = o; touchPending = tp; touchConfirmed = tc;
    repeat (busy) @(negedge clk);
    pulseDone(1'b1, gap, fast, req);
  endtask

  initial begin
    int seen;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(burstStart == 1'b0, "R1", int'(burstStart), 0);
    check(fastMode == 1'b0, "R1", int'(fastMode), 0);
    rstN = 1'b1;
    @(negedge clk);
    // R6 first burst right after reset
    check(burstStart == 1'b1, "R6", int'(burstStart), 1);

    runBurst(2, 0, 0, 0, SLOW_T, 0, "R3");
    runBurst(3, 1, 0, 0, FAST_T, 1, "R2");
    runBurst(1, 0, 1, 0, FAST_T, 1, "R4");
    runBurst(2, 0, 0, 0, SLOW_T, 0, "R5");
    runBurst(2, 0, 0, 1, FAST_T, 1, "R5");
    runBurst(9, 1, 0, 0, FAST_T, 1, "R9");

    // R8: mode holds through a gap while inputs change
    waitStart();
    outOn = 1'b1; touchPending = 1'b0; touchConfirmed = 1'b0;
    @(negedge clk);
    // R9 single-cycle strobe
    check(burstStart == 1'b0, "R9", int'(burstStart), 0);
    pulseDone(1'b1, FAST_T, 1'b1, "R8");
    outOn = 1'b0;
    @(negedge clk);
    check(fastMode == 1'b1, "R8", int'(fastMode), 1);
    waitStart();
    @(negedge clk);
    pulseDone(1'b0, 0, 1'b0, "R8");
    check(fastMode == 1'b0, "R8", int'(fastMode), 0);

    // R7: inhibit during a slow gap abandons it
    repeat (5) @(negedge clk);
    inhibit = 1'b1;
    seen = startSeen;
    repeat (150) @(negedge clk);
    check(startSeen == seen, "R7", startSeen, seen);
    inhibit = 1'b0;
    @(negedge clk);
    check(burstStart == 1'b1, "R6", int'(burstStart), 1);

    // R7: inhibit raised during a burst, done while held
    @(negedge clk);
    inhibit = 1'b1;
    pulseDone(1'b0, 0, 1'b0, "R7");
    seen = startSeen;
    repeat (100) @(negedge clk);
    check(startSeen == seen, "R7", startSeen, seen);
    check(burstStart == 1'b0, "R7", int'(burstStart), 0);
    inhibit = 1'b0;
    @(negedge clk);
    check(burstStart == 1'b1, "R6", int'(burstStart), 1);

    runBurst(2, 0, 1, 0, FAST_T, 1, "R4");
    @(negedge clk);
    waitStart();
    @(negedge clk);
    check(expQ.size() == 0, "R9", expQ.size(), 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule